// File: doc/BRIEF.md
# Single-Channel Quadword Block-Copy DMA Engine

This block is one DMA channel that copies a run of 16-byte quadwords from a source address in memory into a fixed destination window. Software programs four word-wide registers through a simple write port and can read any of them back at any time through a combinational read port. The registers hold the channel control word, the source address, the quadword count and the destination offset. Writing the control word with its start bit set launches the copy. The destination of each quadword is a fixed window base (a parameter) plus the programmed offset, advanced by 16 per quadword.

The copy moves one quadword per beat over three valid/ready channels: read request, read response and write request. A beat issues a read, takes the returned quadword, then issues the write, and only one beat is ever in flight. The source address register advances by 16 and the count register drops by one as each write is accepted, so software can watch progress. When the last beat is accepted, the engine clears the start bit and the count and pulses a one-cycle done interrupt.

Back-pressure rules: once a request valid is raised, it stays high, and its address and data stay unchanged, until the cycle in which ready is high. A transfer happens on a rising edge where valid and ready are both high. The engine raises the response ready only while it waits for read data. The memory side may hold any ready low for any number of cycles.

Top module: `dma_qw_copier`

## Requirements
- R1: After reset all four registers read 0, no request valid is high and the done interrupt is low.
- R2: The register index is address bits [5:4]: 0 control, 1 source address, 2 quadword count, 3 destination offset. While idle, a write stores the full 32-bit value, except the count, which keeps only its low 16 bits (the upper bits read 0). A control write with bit 8 clear starts nothing.
- R3: A control write with bit 8 (start) set while idle, with count N > 0, moves N quadwords. Beat k reads source (address with low 4 bits zeroed) + 16k, and writes the returned 128-bit data to window base + (offset with low 4 bits zeroed) + 16k, in order.
- R4: Each accepted write adds 16 to the source address register and subtracts 1 from the count register. Neither changes before that write is accepted.
- R5: After the last write is accepted, the next clock edge clears control bit 8 and the count. The done interrupt is then high for exactly one cycle.
- R6: A start with count 0 makes no memory request. The done interrupt is high in the second cycle after the write edge, and control bit 8 reads 0.
- R7: A raised request valid holds, with stable address and data, until ready. Only one beat is in flight at a time.
- R8: While a transfer is active (including its completion cycle), writes to the source, count and offset registers are ignored.
- R9: A control write during a transfer is stored as written. If bit 8 is clear, the current beat finishes, the channel goes idle with no interrupt, and the count shows the quadwords not moved. If bit 8 is set, there is no restart.
- R10: A control write in the completion cycle is stored with bit 8 forced to 0, and nothing restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 6 | Register write byte offset, index in bits [5:4] |
| reg_wr_data | input | 32 | Register write value |
| reg_rd_addr | input | 6 | Register read byte offset, index in bits [5:4] |
| reg_rd_data | output | 32 | Register read value (combinational) |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 32 | Read request byte address (16-byte aligned) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine waiting for read data |
| mem_rsp_data | input | 128 | Read data quadword |
| mem_wr_valid | output | 1 | Write request valid |
| mem_wr_ready | input | 1 | Write request accepted |
| mem_wr_addr | output | 32 | Write byte address (16-byte aligned) |
| mem_wr_data | output | 128 | Write data quadword |
| done_irq | output | 1 | One-cycle pulse on normal completion |

## Verification
Two things can land on the same clock edge: a software write to the control word and the engine's own completion, which clears the start bit. The bench provokes this by waiting for the final write handshake and driving a control write with the start bit set, so that it is sampled on the completion edge. It then judges that the control word reads back with its other bits intact and bit 8 clear, that one interrupt was seen, and that no new read was issued. A second overlap is a software stop that arrives while a beat is stalled on write ready. The bench checks that the beat in flight completes and that the count then shows exactly the remainder.

// File: rtl/dma_qw_pkg.sv
package dma_qw_pkg;
  localparam int REG_AW   = 6;
  localparam int STR_BIT  = 8;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_SRC  = 2'd1;
  localparam logic [1:0] IDX_CNT  = 2'd2;
  localparam logic [1:0] IDX_DST  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/dma_qw_regs.sv
module dma_qw_regs
  import dma_qw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CNT_W  = 16,
  parameter int QW_B   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_idx,
  output logic [AW-1:0] rd_data,
  input  logic          busy_i,
  input  logic          beat_i,
  input  logic          fin_i,
  output logic          start_o,
  output logic          run_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [AW-1:0]    ctrl_q, src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;
  logic             idle_wr;

  assign idle_wr = wr_en && !busy_i;
  assign start_o = idle_wr && (wr_idx == IDX_CTRL) && wr_data[STR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en && wr_idx == IDX_CTRL) begin
        ctrl_q <= wr_data;
        if (fin_i) ctrl_q[STR_BIT] <= 1'b0;
      end else if (fin_i) begin
        ctrl_q[STR_BIT] <= 1'b0;
      end

      if (idle_wr && wr_idx == IDX_SRC) src_q <= wr_data;
      else if (beat_i)                  src_q <= src_q + AW'(QW_B);

      if (idle_wr && wr_idx == IDX_DST) dst_q <= wr_data;

      if (fin_i)                             cnt_q <= '0;
      else if (idle_wr && wr_idx == IDX_CNT) cnt_q <= wr_data[CNT_W-1:0];
      else if (beat_i)                       cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    unique case (rd_idx)
      IDX_CTRL: rd_data = ctrl_q;
      IDX_SRC:  rd_data = src_q;
      IDX_CNT:  rd_data = AW'(cnt_q);
      default:  rd_data = dst_q;
    endcase
  end

  assign run_o = ctrl_q[STR_BIT];
  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;

  // R4: every accepted beat advances the source by one quadword
  a_r4_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_i |=> src_q == $past(src_q) + AW'(QW_B));
  // R5: completion leaves start bit and count cleared
  a_r5_fin_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |=> (!ctrl_q[STR_BIT] && cnt_q == '0));
  // R8: destination offset is frozen while busy
  a_r8_dst_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(dst_q));
endmodule

// File: rtl/dma_qw_seq.sv
module dma_qw_seq
  import dma_qw_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          DW       = 128,
  parameter int          CNT_W    = 16,
  parameter logic [AW-1:0] WIN_BASE = 32'h4000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic             beat_o,
  output logic             fin_o,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             mem_wr_valid,
  input  logic             mem_wr_ready,
  output logic [AW-1:0]    mem_wr_addr,
  output logic [DW-1:0]    mem_wr_data,
  output logic             done_irq
);
  localparam int QW_B  = DW / 8;
  localparam int QW_SH = $clog2(QW_B);

  seq_state_t      st_q, st_d;
  logic [AW-1:0]   wptr_q;
  logic [DW-1:0]   buf_q;
  logic            irq_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = (cnt_i == '0) ? ST_FIN : ST_RD;
      ST_RD:   if (mem_rd_ready) st_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) st_d = ST_WR;
      ST_WR: begin
        if (mem_wr_ready) begin
          if (!run_i)                   st_d = ST_IDLE;
          else if (cnt_i == CNT_W'(1))  st_d = ST_FIN;
          else                          st_d = ST_RD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wptr_q <= '0;
      buf_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= (st_q == ST_FIN);
      if (st_q == ST_IDLE && start_i)
        wptr_q <= WIN_BASE + {dst_i[AW-1:QW_SH], QW_SH'(0)};
      else if (beat_o)
        wptr_q <= wptr_q + AW'(QW_B);
      if (st_q == ST_WAIT && mem_rsp_valid)
        buf_q <= mem_rsp_data;
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign beat_o        = (st_q == ST_WR) && mem_wr_ready;
  assign fin_o         = (st_q == ST_FIN);
  assign mem_rd_valid  = (st_q == ST_RD);
  assign mem_rd_addr   = {src_i[AW-1:QW_SH], QW_SH'(0)};
  assign mem_rsp_ready = (st_q == ST_WAIT);
  assign mem_wr_valid  = (st_q == ST_WR);
  assign mem_wr_addr   = wptr_q;
  assign mem_wr_data   = buf_q;
  assign done_irq      = irq_q;

  // R7: read request held steady under back-pressure
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  // R7: write request held steady under back-pressure
  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
  // R5: the done interrupt is a single-cycle pulse
  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  // R6: a zero-count start never touches memory
  a_r6_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && cnt_i == '0) |=> !mem_rd_valid);
endmodule

// File: rtl/dma_qw_copier.sv
module dma_qw_copier
  import dma_qw_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 128,
  parameter int            CNT_W    = 16,
  parameter logic [AW-1:0] WIN_BASE = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_wr_addr,
  input  logic [AW-1:0]     reg_wr_data,
  input  logic [REG_AW-1:0] reg_rd_addr,
  output logic [AW-1:0]     reg_rd_data,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [DW-1:0]     mem_wr_data,
  output logic              done_irq
);
  localparam int QW_B = DW / 8;

  logic             start_w, run_w, busy_w, beat_w, fin_w;
  logic [AW-1:0]    src_w, dst_w;
  logic [CNT_W-1:0] cnt_w;

  dma_qw_regs #(.AW(AW), .CNT_W(CNT_W), .QW_B(QW_B)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_idx  (reg_wr_addr[5:4]),
    .wr_data (reg_wr_data),
    .rd_idx  (reg_rd_addr[5:4]),
    .rd_data (reg_rd_data),
    .busy_i  (busy_w),
    .beat_i  (beat_w),
    .fin_i   (fin_w),
    .start_o (start_w),
    .run_o   (run_w),
    .src_o   (src_w),
    .dst_o   (dst_w),
    .cnt_o   (cnt_w)
  );

  dma_qw_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .WIN_BASE(WIN_BASE)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_w),
    .run_i         (run_w),
    .src_i         (src_w),
    .dst_i         (dst_w),
    .cnt_i         (cnt_w),
    .busy_o        (busy_w),
    .beat_o        (beat_w),
    .fin_o         (fin_w),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_ready  (mem_wr_ready),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data),
    .done_irq      (done_irq)
  );
endmodule

// File: tb/dma_qw_copier_bench.sv
`timescale 1ns/1ps
module dma_qw_copier_bench;
  localparam logic [31:0] WIN = 32'h4000_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic [5:0]   reg_wr_addr = '0;
  logic [31:0]  reg_wr_data = '0;
  logic [5:0]   reg_rd_addr = '0;
  logic [31:0]  reg_rd_data;
  logic         mem_rd_valid, mem_rd_ready = 1'b0;
  logic [31:0]  mem_rd_addr;
  logic         mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [127:0] mem_rsp_data = '0;
  logic         mem_wr_valid, mem_wr_ready = 1'b0;
  logic [31:0]  mem_wr_addr;
  logic [127:0] mem_wr_data;
  logic         done_irq;

  dma_qw_copier u_dma_qw_copier (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int pat = 0, wr_limit = 1000000, cyc = 0;
  int rd_cnt = 0, wr_beats = 0, irq_cnt = 0;
  logic [31:0] src_base = '0, dst_base = '0;
  event wr_ev;

  function automatic logic [127:0] qw_pat(logic [31:0] a);
    return {a ^ 32'h1111_1111, a, ~a, a + 32'h5};
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model, all changes at the falling edge
  initial begin : mem_model
    bit rd_pend = 0, wr_pend = 0, rsp_pend = 0, have = 0, prev_stall = 0;
    int lat = 0;
    logic [31:0] pend_addr = '0, prev_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (done_irq) irq_cnt++;
      if (wr_pend) wr_beats++;
      if (rsp_pend) mem_rsp_valid = 1'b0;
      if (rd_pend) begin have = 1; lat = pat; rd_cnt++; end
      if (prev_stall) check(mem_rd_valid && mem_rd_addr == prev_addr, "R7 rd hold",
                            {96'd0, mem_rd_addr}, {96'd0, prev_addr});
      if (have && !mem_rsp_valid) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = qw_pat(pend_addr);
          have = 0;
        end else lat--;
      end
      case (pat)
        0:       mem_rd_ready = 1'b1;
        1:       mem_rd_ready = cyc[0];
        default: mem_rd_ready = (cyc % 3) == 0;
      endcase
      mem_wr_ready = mem_rd_ready && (wr_beats < wr_limit);
      rsp_pend   = mem_rsp_valid && mem_rsp_ready;
      rd_pend    = mem_rd_valid && mem_rd_ready;
      prev_stall = mem_rd_valid && !mem_rd_ready;
      prev_addr  = mem_rd_addr;
      wr_pend    = mem_wr_valid && mem_wr_ready;
      if (rd_pend) begin
        pend_addr = mem_rd_addr;
        check(mem_rd_addr == src_base + 32'(16 * rd_cnt), "R3 read address",
              {96'd0, mem_rd_addr}, {96'd0, src_base + 32'(16 * rd_cnt)});
      end
      if (wr_pend) begin
        check(mem_wr_addr == dst_base + 32'(16 * wr_beats), "R3 write address",
              {96'd0, mem_wr_addr}, {96'd0, dst_base + 32'(16 * wr_beats)});
        check(mem_wr_data == qw_pat(src_base + 32'(16 * wr_beats)), "R3 write data",
              mem_wr_data, qw_pat(src_base + 32'(16 * wr_beats)));
        -> wr_ev;
      end
    end
  end

  task automatic reg_write(int idx, logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 6'(idx << 4); reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(int idx, output logic [31:0] v);
    reg_rd_addr = 6'(idx << 4);
    #0.5 v = reg_rd_data;
  endtask

  task automatic expect_reg(int idx, logic [31:0] exp, string tag);
    logic [31:0] v;
    reg_read(idx, v);
    check(v == exp, tag, {96'd0, v}, {96'd0, exp});
  endtask

  task automatic arm(logic [31:0] m, logic [31:0] t, int q);
    src_base = m & ~32'hF; dst_base = WIN + (t & ~32'hF);
    rd_cnt = 0; wr_beats = 0; irq_cnt = 0;
    reg_write(1, m); reg_write(3, t); reg_write(2, 32'(q));
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000 && irq_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) expect_reg(i, 32'h0, "R1 reset register");
    check(!mem_rd_valid && !mem_wr_valid && !done_irq, "R1 outputs idle",
          {125'd0, mem_rd_valid, mem_wr_valid, done_irq}, 128'd0);

    // R2 register map while idle
    reg_write(1, 32'h1234_5678); expect_reg(1, 32'h1234_5678, "R2 source");
    reg_write(2, 32'hABCD_1234); expect_reg(2, 32'h0000_1234, "R2 count width");
    reg_write(3, 32'h0BAD_F00D); expect_reg(3, 32'h0BAD_F00D, "R2 offset");
    rd_cnt = 0;
    reg_write(0, 32'h0000_00FF); expect_reg(0, 32'h0000_00FF, "R2 control");
    repeat (10) @(negedge clk);
    check(rd_cnt == 0, "R2 no start without bit 8", 128'(rd_cnt), 128'd0);

    // R6 zero count start: exact interrupt timing
    arm(32'h100, 32'h20, 0);
    reg_write(0, 32'h100);
    check(!done_irq, "R6 irq low first cycle", {127'd0, done_irq}, 128'd0);
    @(negedge clk);
    check(done_irq, "R6 irq high second cycle", {127'd0, done_irq}, 128'd1);
    @(negedge clk);
    check(!done_irq, "R5 irq single cycle", {127'd0, done_irq}, 128'd0);
    repeat (5) @(negedge clk);
    check(rd_cnt == 0, "R6 no memory access", 128'(rd_cnt), 128'd0);
    expect_reg(0, 32'h0, "R6 start bit cleared");

    // R3 R4 R5 sweep over counts, back-pressure patterns and alignment
    for (int q = 0; q < 5; q++)
      for (int p = 0; p < 3; p++)
        for (int a = 0; a < 2; a++) begin
          logic [31:0] m, t;
          m = (a == 0) ? 32'h0000_1000 : 32'h0002_3457;
          t = (a == 0) ? 32'h0000_0040 : 32'h0000_0a0c;
          pat = p;
          arm(m, t, q);
          reg_write(0, 32'h0000_0131);
          wait_irq();
          check(wr_beats == q, "R3 beat count", 128'(wr_beats), 128'(q));
          check(irq_cnt == 1, "R5 one interrupt", 128'(irq_cnt), 128'd1);
          expect_reg(0, 32'h0000_0031, "R5 start bit cleared");
          expect_reg(2, 32'h0, "R5 count cleared");
          expect_reg(1, m + 32'(16 * q), "R4 source advanced");
        end
    pat = 0;

    // R4 R8 mid-transfer progress and ignored writes
    wr_limit = 1;
    arm(32'h0000_2000, 32'h0000_0100, 3);
    reg_write(0, 32'h100);
    repeat (30) @(negedge clk);
    check(wr_beats == 1, "R4 stalled after one beat", 128'(wr_beats), 128'd1);
    expect_reg(2, 32'd2, "R4 count mid transfer");
    expect_reg(1, 32'h0000_2010, "R4 source mid transfer");
    reg_write(1, 32'hDEAD_0000); reg_write(2, 32'd9); reg_write(3, 32'h7770);
    expect_reg(1, 32'h0000_2010, "R8 source write ignored");
    expect_reg(2, 32'd2, "R8 count write ignored");
    expect_reg(3, 32'h0000_0100, "R8 offset write ignored");
    wr_limit = 1000000;
    wait_irq();
    check(wr_beats == 3, "R8 transfer unaffected", 128'(wr_beats), 128'd3);
    expect_reg(1, 32'h0000_2030, "R8 final source");

    // R9 stop while a beat is stalled
    wr_limit = 1;
    arm(32'h0000_3000, 32'h0000_0200, 4);
    reg_write(0, 32'h100);
    repeat (30) @(negedge clk);
    reg_write(0, 32'h0000_0000);
    wr_limit = 1000000;
    repeat (40) @(negedge clk);
    check(wr_beats == 2, "R9 stop finishes current beat", 128'(wr_beats), 128'd2);
    check(rd_cnt == 2, "R9 no read after stop", 128'(rd_cnt), 128'd2);
    check(irq_cnt == 0, "R9 no interrupt on stop", 128'(irq_cnt), 128'd0);
    expect_reg(2, 32'd2, "R9 count shows remainder");
    expect_reg(0, 32'h0, "R9 control stored");

    // R9 control rewrite with start set does not restart
    wr_limit = 1;
    arm(32'h0000_4000, 32'h0000_0300, 2);
    reg_write(0, 32'h100);
    repeat (30) @(negedge clk);
    reg_write(0, 32'h0000_01FF);
    wr_limit = 1000000;
    wait_irq();
    check(wr_beats == 2 && rd_cnt == 2, "R9 no restart", 128'(rd_cnt), 128'd2);
    check(irq_cnt == 1, "R9 single interrupt", 128'(irq_cnt), 128'd1);
    expect_reg(0, 32'h0000_00FF, "R9 control stored as written");

    // R10 control write on the completion edge
    arm(32'h0000_5000, 32'h0000_0400, 1);
    reg_write(0, 32'h100);
    @(wr_ev);
    @(posedge clk);
    reg_write(0, 32'h0000_01AB);
    repeat (20) @(negedge clk);
    expect_reg(0, 32'h0000_00AB, "R10 start bit cleared by completion");
    check(irq_cnt == 1, "R10 one interrupt", 128'(irq_cnt), 128'd1);
    check(rd_cnt == 1, "R10 no restart", 128'(rd_cnt), 128'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule